// File: doc/BRIEF.md
# Word/Element Memory Row Value Tracker

This block follows a sorted stream of memory accesses and keeps the four-element word state that each access row must carry. Each row is either a read or a write. A write covers either a whole word or one element picked by a two-bit index. For every valid row the block works out the word value after the access. Any element the access does not write either keeps the value it had on the previous row or starts from zero. Which of the two applies depends on a flag saying whether the context and word address match the previous row.

The block also checks read rows. On a read, the values the row claims to hold are compared with the values the tracker expects, and a mismatch is flagged. Results come out one clock after the row is presented. A start pulse marks the next row as the first row of a new stream.

Top module: `wordmem_row_tracker`

## Requirements
- R1: While and after synchronous reset, out_valid, out_rd_err and out_vals are all zero until the first row arrives.
- R2: out_valid is high in exactly the cycle after a cycle with row_valid high, and low after a cycle with row_valid low.
- R3: A word write (row_is_read=0, row_is_word=1) sets every lane i of out_vals (bits [i*ELEM_W +: ELEM_W]) to the same lane of wr_word.
- R4: An element write (row_is_read=0, row_is_word=0) writes wr_elem into lane k, where k = row_idx[1]*2 + row_idx[0]. The other three lanes are untouched.
- R5: When row_same_cw=1 and the row is not the first of a stream, each untouched lane keeps its value from the previous row.
- R6: When row_same_cw=0, each untouched lane becomes zero.
- R7: The first row after reset or after a start pulse treats untouched lanes as zero, whatever row_same_cw is. A start in the same cycle as a row makes that row the first.
- R8: On a read, no lane is touched. out_rd_err is 1 exactly when rd_vals differs from the expected out_vals of that row.
- R9: out_rd_err is 0 for write rows and in cycles where out_valid is 0.
- R10: Cycles with row_valid=0 change neither out_vals nor the kept word state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Starts a new stream; the next row is treated as the first |
| row_valid | input | 1 | A row is presented this cycle |
| row_is_read | input | 1 | 1 = read, 0 = write |
| row_is_word | input | 1 | 1 = whole-word access, 0 = single element |
| row_idx | input | 2 | Element index for element accesses |
| row_same_cw | input | 1 | Context and word address equal those of the previous row |
| wr_word | input | 256 | Word data for a word write, lane i at bits [i*64 +: 64] |
| wr_elem | input | 64 | Element data for an element write |
| rd_vals | input | 256 | Values claimed by a read row, checked against expectation |
| out_valid | output | 1 | Registered result valid |
| out_vals | output | 256 | Post-access word value of the last row |
| out_rd_err | output | 1 | Read row values differed from expectation |

## Verification
A wrong kept word or a wrong first-row flag shows up at the next row that leaves a lane untouched. That row can be a read with row_same_cw=1 or a partial element write. The error appears as wrong out_vals, plus out_rd_err on a read, one cycle after that row. A lane mux or index decode error shows in out_vals one cycle after the write itself. The directed sequences therefore follow every write with same-word reads and partial writes, and insert idle cycles and start pulses between them, so that a corrupted state cannot go unobserved.

// File: rtl/wmt_pkg.sv
package wmt_pkg;
  typedef struct packed {
    logic is_read;
    logic is_word;
    logic keep_prev;
  } row_ctrl_t;

  function automatic logic lane_written(input row_ctrl_t c, input logic hit);
    return !c.is_read && (c.is_word || hit);
  endfunction
endpackage

// File: rtl/wmt_idx_decode.sv
module wmt_idx_decode #(
  parameter int LANES = 4,
  localparam int IDX_W = $clog2(LANES)
) (
  input  logic [IDX_W-1:0] idx,
  output logic [LANES-1:0] hit
);
  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      hit[i] = (idx == IDX_W'(i));
    end
  end
endmodule

// File: rtl/wmt_lane.sv
module wmt_lane
  import wmt_pkg::*;
#(
  parameter int ELEM_W = 64
) (
  input  row_ctrl_t         ctrl,
  input  logic              hit,
  input  logic [ELEM_W-1:0] prev,
  input  logic [ELEM_W-1:0] word_lane,
  input  logic [ELEM_W-1:0] elem,
  output logic [ELEM_W-1:0] nxt
);
  logic [ELEM_W-1:0] base;
  always_comb begin
    base = ctrl.keep_prev ? prev : '0;
    if (lane_written(ctrl, hit)) begin
      nxt = ctrl.is_word ? word_lane : elem;
    end else begin
      nxt = base;
    end
  end
endmodule

// File: rtl/wmt_read_check.sv
module wmt_read_check #(
  parameter int WORD_W = 256
) (
  input  logic              is_read,
  input  logic [WORD_W-1:0] expect_vals,
  input  logic [WORD_W-1:0] claim_vals,
  output logic              mismatch
);
  assign mismatch = is_read && (expect_vals != claim_vals);
endmodule

// File: rtl/wordmem_row_tracker.sv
module wordmem_row_tracker
  import wmt_pkg::*;
#(
  parameter int ELEM_W = 64,
  parameter int LANES  = 4,
  localparam int IDX_W  = $clog2(LANES),
  localparam int WORD_W = ELEM_W * LANES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              row_valid,
  input  logic              row_is_read,
  input  logic              row_is_word,
  input  logic [IDX_W-1:0]  row_idx,
  input  logic              row_same_cw,
  input  logic [WORD_W-1:0] wr_word,
  input  logic [ELEM_W-1:0] wr_elem,
  input  logic [WORD_W-1:0] rd_vals,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_vals,
  output logic              out_rd_err
);
  logic [WORD_W-1:0] state_q;
  logic [WORD_W-1:0] next_word;
  logic              fresh_q;
  logic              fresh_now;
  logic [LANES-1:0]  lane_hit;
  logic              rd_mismatch;
  row_ctrl_t         ctrl;

  assign fresh_now = fresh_q | start;

  always_comb begin
    ctrl.is_read   = row_is_read;
    ctrl.is_word   = row_is_word;
    ctrl.keep_prev = row_same_cw & ~fresh_now;
  end

  wmt_idx_decode #(.LANES(LANES)) u_dec (
    .idx (row_idx),
    .hit (lane_hit)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    wmt_lane #(.ELEM_W(ELEM_W)) u_lane (
      .ctrl      (ctrl),
      .hit       (lane_hit[g]),
      .prev      (state_q[g*ELEM_W +: ELEM_W]),
      .word_lane (wr_word[g*ELEM_W +: ELEM_W]),
      .elem      (wr_elem),
      .nxt       (next_word[g*ELEM_W +: ELEM_W])
    );
  end

  wmt_read_check #(.WORD_W(WORD_W)) u_chk (
    .is_read     (row_is_read),
    .expect_vals (next_word),
    .claim_vals  (rd_vals),
    .mismatch    (rd_mismatch)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      fresh_q <= 1'b1;
    end else if (row_valid) begin
      fresh_q <= 1'b0;
    end else if (start) begin
      fresh_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= '0;
      out_vals   <= '0;
      out_valid  <= 1'b0;
      out_rd_err <= 1'b0;
    end else begin
      out_valid <= row_valid;
      if (row_valid) begin
        state_q    <= next_word;
        out_vals   <= next_word;
        out_rd_err <= rd_mismatch;
      end else begin
        out_rd_err <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/wordmem_row_tracker_chk.sv
module wordmem_row_tracker_chk #(
  parameter int ELEM_W = 64,
  parameter int LANES  = 4,
  localparam int IDX_W  = $clog2(LANES),
  localparam int WORD_W = ELEM_W * LANES
) (
  input logic              clk,
  input logic              rst,
  input logic              row_valid,
  input logic              row_is_read,
  input logic              row_is_word,
  input logic              row_same_cw,
  input logic [WORD_W-1:0] wr_word,
  input logic [WORD_W-1:0] rd_vals,
  input logic              out_valid,
  input logic [WORD_W-1:0] out_vals,
  input logic              out_rd_err
);
  // R2
  valid_follows_row_chk: assert property (@(posedge clk) disable iff (rst)
    row_valid |=> out_valid);
  // R2
  valid_drops_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !row_valid |=> !out_valid);
  // R3
  word_write_lanes_chk: assert property (@(posedge clk) disable iff (rst)
    (row_valid && !row_is_read && row_is_word) |=> (out_vals == $past(wr_word)));
  // R6
  changed_word_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (row_valid && row_is_read && !row_same_cw) |=> (out_vals == '0));
  // R8
  read_compare_chk: assert property (@(posedge clk) disable iff (rst)
    (row_valid && row_is_read) |=> (out_rd_err == (out_vals != $past(rd_vals))));
  // R9
  err_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
    out_rd_err |-> out_valid);
  // R9
  write_no_err_chk: assert property (@(posedge clk) disable iff (rst)
    (row_valid && !row_is_read) |=> !out_rd_err);
  // R10
  idle_holds_chk: assert property (@(posedge clk) disable iff (rst)
    !row_valid |=> $stable(out_vals));
endmodule

bind wordmem_row_tracker wordmem_row_tracker_chk #(.ELEM_W(ELEM_W), .LANES(LANES)) u_chk_bind (
  .clk         (clk),
  .rst         (rst),
  .row_valid   (row_valid),
  .row_is_read (row_is_read),
  .row_is_word (row_is_word),
  .row_same_cw (row_same_cw),
  .wr_word     (wr_word),
  .rd_vals     (rd_vals),
  .out_valid   (out_valid),
  .out_vals    (out_vals),
  .out_rd_err  (out_rd_err)
);

// File: tb/wordmem_row_tracker_tb.sv
module wordmem_row_tracker_tb;
  localparam int EW = 64;
  localparam int WW = 4 * EW;

  logic          clk = 1'b0;
  logic          rst, start, row_valid, row_is_read, row_is_word, row_same_cw;
  logic [1:0]    row_idx;
  logic [WW-1:0] wr_word, rd_vals, out_vals;
  logic [EW-1:0] wr_elem;
  logic          out_valid, out_rd_err;

  int n_chk = 0;
  int n_bad = 0;
  logic [WW-1:0] model = '0;
  bit            model_first = 1'b1;

  always #5 clk = ~clk;

  wordmem_row_tracker #(.ELEM_W(EW), .LANES(4)) u_dut (
    .clk(clk), .rst(rst), .start(start), .row_valid(row_valid),
    .row_is_read(row_is_read), .row_is_word(row_is_word), .row_idx(row_idx),
    .row_same_cw(row_same_cw), .wr_word(wr_word), .wr_elem(wr_elem),
    .rd_vals(rd_vals), .out_valid(out_valid), .out_vals(out_vals),
    .out_rd_err(out_rd_err)
  );

  task automatic check1(input string tag, input logic [WW-1:0] got, input logic [WW-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  function automatic logic [WW-1:0] expect_row(input bit rd, input bit wd, input logic [1:0] idx,
                                               input bit same, input logic [WW-1:0] w,
                                               input logic [EW-1:0] e);
    logic [WW-1:0] r;
    r = (model_first || !same) ? '0 : model;
    if (!rd) begin
      if (wd) r = w;
      else r[idx*EW +: EW] = e;
    end
    return r;
  endfunction

  task automatic do_row(input string tag, input bit rd, input bit wd, input logic [1:0] idx,
                        input bit same, input logic [WW-1:0] w, input logic [EW-1:0] e,
                        input logic [WW-1:0] claim, input bit with_start);
    logic [WW-1:0] exp;
    @(negedge clk);
    if (with_start) model_first = 1'b1;
    exp = expect_row(rd, wd, idx, same, w, e);
    start = with_start; row_valid = 1'b1; row_is_read = rd; row_is_word = wd;
    row_idx = idx; row_same_cw = same; wr_word = w; wr_elem = e; rd_vals = claim;
    @(posedge clk); #1;
    model = exp; model_first = 1'b0;
    start = 1'b0;
    check1({tag, " valid R2"}, WW'(out_valid), WW'(1));
    check1({tag, " vals"}, out_vals, exp);
    check1({tag, " err R8/R9"}, WW'(out_rd_err), WW'(rd && (claim != exp)));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      row_valid = 1'b0; start = 1'b0;
      @(posedge clk); #1;
      check1("idle R2", WW'(out_valid), WW'(0));
      check1("idle R9", WW'(out_rd_err), WW'(0));
      check1("idle R10", out_vals, model);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk);
    start = 1'b1; row_valid = 1'b0;
    @(posedge clk); #1;
    start = 1'b0;
    model_first = 1'b1;
  endtask

  function automatic logic [WW-1:0] mk(input logic [EW-1:0] a, b, c, d);
    return {d, c, b, a};
  endfunction

  task automatic t_reset();
    @(negedge clk);
    rst = 1'b1; start = 1'b0; row_valid = 1'b0; row_is_read = 0; row_is_word = 0;
    row_idx = 0; row_same_cw = 0; wr_word = '1; wr_elem = '1; rd_vals = '0;
    repeat (2) @(posedge clk);
    #1;
    check1("R1 valid", WW'(out_valid), WW'(0));
    check1("R1 vals", out_vals, '0);
    check1("R1 err", WW'(out_rd_err), WW'(0));
    @(negedge clk); rst = 1'b0;
    model = '0; model_first = 1'b1;
    idle(1);
  endtask

  task automatic t_first_row();
    // R7: first row with same flag set still starts from zero
    do_row("R7 first elem", 0, 0, 2'd1, 1, mk(1, 2, 3, 4), 64'hAAAA_0001, '0, 0);
    do_row("R7 first read", 1, 0, 2'd0, 1, '0, '0, mk(0, 64'hAAAA_0001, 0, 0), 0);
  endtask

  task automatic t_word_write();
    do_row("R3 word", 0, 1, 2'd3, 1, mk(64'h11, 64'h22, 64'h33, 64'h44), '0, '0, 0);
    do_row("R3 word2", 0, 1, 2'd0, 0, mk(64'hF0F0, 64'h0F0F, 64'hDEAD, 64'hBEEF), '0, '0, 0);
  endtask

  task automatic t_elem_writes();
    for (int k = 0; k < 4; k++) begin
      do_row("R4 elem", 0, 0, 2'(k), 1, '1, 64'hC0DE_0000 + 64'(k), '0, 0);
    end
    do_row("R4 readback", 1, 0, 2'd2, 1, '0, '0,
           mk(64'hC0DE_0000, 64'hC0DE_0001, 64'hC0DE_0002, 64'hC0DE_0003), 0);
  endtask

  task automatic t_keep_vs_zero();
    do_row("R5 setup", 0, 1, 2'd0, 0, mk(5, 6, 7, 8), '0, '0, 0);
    do_row("R5 keep elem", 0, 0, 2'd3, 1, '0, 64'h99, '0, 0);
    do_row("R5 keep read", 1, 1, 2'd0, 1, '0, '0, mk(5, 6, 7, 64'h99), 0);
    do_row("R6 zero elem", 0, 0, 2'd2, 0, '1, 64'h77, '0, 0);
    do_row("R6 zero read", 1, 0, 2'd1, 0, '0, '0, '0, 0);
  endtask

  task automatic t_read_errors();
    do_row("R8 setup", 0, 1, 2'd0, 0, mk(64'h1, 64'h2, 64'h3, 64'h4), '0, '0, 0);
    do_row("R8 bad lane3", 1, 1, 2'd0, 1, '0, '0, mk(64'h1, 64'h2, 64'h3, 64'h5), 0);
    do_row("R8 bad lane0", 1, 0, 2'd0, 1, '0, '0, mk(64'h0, 64'h2, 64'h3, 64'h4), 0);
    do_row("R8 good", 1, 0, 2'd3, 1, '0, '0, mk(64'h1, 64'h2, 64'h3, 64'h4), 0);
    do_row("R9 write wrong claim", 0, 0, 2'd1, 1, '0, 64'h2, '1, 0);
  endtask

  task automatic t_idle_hold();
    do_row("R10 setup", 0, 1, 2'd0, 0, mk(64'hA, 64'hB, 64'hC, 64'hD), '0, '0, 0);
    idle(3);
    do_row("R10 after idle", 1, 0, 2'd0, 1, '0, '0, mk(64'hA, 64'hB, 64'hC, 64'hD), 0);
  endtask

  task automatic t_start();
    pulse_start();
    do_row("R7 after start", 1, 0, 2'd0, 1, '0, '0, '0, 0);
    do_row("R7 restock", 0, 1, 2'd0, 1, mk(9, 9, 9, 9), '0, '0, 0);
    do_row("R7 start same cycle", 0, 0, 2'd0, 1, '0, 64'h42, '0, 1);
    do_row("R7 post start keep", 1, 0, 2'd0, 1, '0, '0, mk(64'h42, 0, 0, 0), 0);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_first_row();
        t_word_write();
        t_elem_writes();
        t_keep_vs_zero();
        t_read_errors();
        t_idle_hold();
        t_start();
        idle(1);
      end
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired got=hung exp=done");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule